// File: doc/BRIEF.md
# Video RAM Block-Transfer DMA Engine

This engine copies bytes into the video RAM window in units of 16-byte blocks. Software loads a 16-bit source pointer and a 16-bit destination pointer through four byte-wide address registers. Writing the control register then starts a copy. The control value holds a mode bit and a block count. The source is forced to a block boundary and must lie outside video RAM. The destination is folded into the 8 KiB video RAM window at 0x8000 and is also block aligned.

There are two modes. In general mode the whole length is copied at once, and the CPU is stalled for as long as the copy runs. In blanking mode the engine arms itself and waits. Each pulse on the blanking input then moves one 16-byte block, until the block count runs out. Each byte takes a read cycle followed by a write cycle on a single memory master port. When a transfer ends, the advanced pointers are written back into the address registers. The control register records the progress of the copy.

Top module: `vram_blk_dma`

## Requirements
- R1: An accepted start loads the source as {addr reg 0, addr reg 1} with bits 3:0 cleared, and the destination as ({addr reg 2, addr reg 3} & 0x1FF0) | 0x8000. The address registers keep their raw written values until the transfer completes.
- R2: A control write whose masked source lies in 0x8000–0x9FFF is ignored. No memory request follows, busy stays low, and the control register keeps its old value.
- R3: Control value bit 7 selects blanking mode (1) or general mode (0). Bits 6:0 give N, and the length is (N+1)×16 bytes. A general start, made while blanking mode is not armed, issues its first read in the cycle after the write.
- R4: Each byte takes two cycles. The first is a read cycle (mem_req_o=1, mem_we_o=0, address = source), in which mem_rdata_i is sampled. The second is a write cycle (mem_req_o=1, mem_we_o=1, address = destination, data = the byte read). cpu_stall_o is high in both cycles.
- R5: The source and destination pointers each advance by one after every byte.
- R6: When a general transfer ends, the address registers hold the advanced source and destination, control bit 7 becomes 1, and busy_o falls in the cycle after the last write.
- R7: In blanking mode nothing moves until a blanking pulse arrives. Each pulse received while the engine is armed and idle moves exactly 16 bytes. After each block the control register is decremented and the advanced pointers are written back.
- R8: Blanking mode disarms when a decrement leaves control bit 7 clear. After that, blanking pulses are ignored. busy_o stays high from the start until the final block's last byte.
- R9: A general-mode control write made while blanking mode is armed disarms it and starts no transfer.
- R10: Control writes made while a byte transfer is in progress are ignored.
- R11: After reset all registers read 0, and mem_req_o, cpu_stall_o and busy_o are low.
- R12: reg_rdata_o returns address registers 0–3 for selects 0–3 and the control register for select 4. Any other select returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select (0–3 address bytes, 4 control) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_sel_i |
| hblank_i | input | 1 | Blanking-period pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, same cycle as request |
| cpu_stall_o | output | 1 | CPU stall while bytes move |
| busy_o | output | 1 | Transfer running or blanking mode armed |

## Verification
A table of general-mode starts covers several cases. These include unaligned low source bits, an all-ones destination that must fold to 0x9FF0, a source just below and one just above the video RAM window, and lengths of one to four blocks. Together they separate the masking, the length decode and the per-byte pointer advance. The memory model returns an address-derived byte, so a wrong source or a swapped phase shows up as wrong write data. Directed cases cover rejected sources at both edges of the window, a two-block blanking run with a pulse after disarm, a cancel by a general write, a control write during a transfer, and the reset and read-port values.

// File: rtl/vram_blk_dma_pkg.sv
package vram_blk_dma_pkg;
  typedef enum logic [1:0] {XF_IDLE = 2'd0, XF_RD = 2'd1, XF_WR = 2'd2} xf_state_e;
  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTL    = 3'd4;
endpackage

// File: rtl/vram_blk_dma_xfer.sv
module vram_blk_dma_xfer
  import vram_blk_dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic             go_i,
  input  logic [CNT_W-1:0] nbytes_i,
  output logic             active_o,
  output logic             done_o,
  output logic [AW-1:0]    src_nxt_o,
  output logic [AW-1:0]    dst_nxt_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i
);
  xf_state_e        state_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    data_q;
  logic             last_byte;

  assign last_byte = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      if (load_i) begin
        src_q <= src_i;
        dst_q <= dst_i;
      end
      unique case (state_q)
        XF_IDLE: if (go_i) begin
          cnt_q   <= nbytes_i;
          state_q <= XF_RD;
        end
        XF_RD: begin
          data_q  <= mem_rdata_i;
          state_q <= XF_WR;
        end
        XF_WR: begin
          src_q   <= src_nxt_o;
          dst_q   <= dst_nxt_o;
          cnt_q   <= cnt_q - CNT_W'(1);
          state_q <= last_byte ? XF_IDLE : XF_RD;
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign src_nxt_o   = src_q + AW'(1);
  assign dst_nxt_o   = dst_q + AW'(1);
  assign active_o    = (state_q != XF_IDLE);
  assign done_o      = (state_q == XF_WR) && last_byte;
  assign mem_req_o   = active_o;
  assign mem_we_o    = (state_q == XF_WR);
  assign mem_addr_o  = mem_we_o ? dst_q : src_q;
  assign mem_wdata_o = data_q;

  // R4
  rd_before_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_req_o && !mem_we_o));

  // R5
  wr_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o, 2)) |-> (mem_addr_o == $past(mem_addr_o, 2) + AW'(1)));
endmodule

// File: rtl/vram_blk_dma_regs.sv
module vram_blk_dma_regs
  import vram_blk_dma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int BLK_BYTES = 16,
  parameter int VRAM_BASE = 'h8000,
  parameter int VRAM_SIZE = 'h2000,
  parameter int CNT_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             hblank_i,
  input  logic             xfer_active_i,
  input  logic             done_i,
  input  logic [AW-1:0]    src_nxt_i,
  input  logic [AW-1:0]    dst_nxt_i,
  output logic             load_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic             go_o,
  output logic [CNT_W-1:0] nbytes_o,
  output logic             blank_o
);
  localparam int            LEN_W      = DW - 1;
  localparam int            BLK_LG     = $clog2(BLK_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BLK_BYTES - 1);
  localparam logic [AW-1:0] DST_MASK   = AW'(VRAM_SIZE - 1) & ALIGN_MASK;
  localparam logic [AW-1:0] DST_BASE   = AW'(VRAM_BASE);

  logic [DW-1:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, ctl_q, ctl_dec;
  logic          blank_q, ctl_wr, src_bad, accept, gen_go, blk_go;

  assign src_o   = {src_hi_q, src_lo_q} & ALIGN_MASK;
  assign dst_o   = ({dst_hi_q, dst_lo_q} & DST_MASK) | DST_BASE;
  assign src_bad = (32'(src_o) >= VRAM_BASE) && (32'(src_o) < VRAM_BASE + VRAM_SIZE);
  assign ctl_wr  = we_i && (sel_i == SEL_CTL) && !xfer_active_i;
  assign accept  = ctl_wr && !src_bad;
  assign gen_go  = accept && !wdata_i[DW-1] && !blank_q;
  assign blk_go  = blank_q && hblank_i && !xfer_active_i && !accept;
  assign ctl_dec = ctl_q - DW'(1);

  assign load_o   = accept;
  assign go_o     = gen_go || blk_go;
  assign nbytes_o = gen_go ? ((CNT_W'(wdata_i[LEN_W-1:0]) + CNT_W'(1)) << BLK_LG)
                           : CNT_W'(BLK_BYTES);
  assign blank_o  = blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_hi_q <= '0; src_lo_q <= '0; dst_hi_q <= '0; dst_lo_q <= '0;
      ctl_q    <= '0;
      blank_q  <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (sel_i)
          SEL_SRC_HI: src_hi_q <= wdata_i;
          SEL_SRC_LO: src_lo_q <= wdata_i;
          SEL_DST_HI: dst_hi_q <= wdata_i;
          SEL_DST_LO: dst_lo_q <= wdata_i;
          default: ;
        endcase
      end
      if (accept) begin
        ctl_q   <= wdata_i;
        blank_q <= wdata_i[DW-1];
      end
      if (done_i) begin
        {src_hi_q, src_lo_q} <= src_nxt_i;
        {dst_hi_q, dst_lo_q} <= dst_nxt_i;
        if (blank_q) begin
          ctl_q <= ctl_dec;
          if (!ctl_dec[DW-1]) blank_q <= 1'b0;
        end else begin
          ctl_q[DW-1] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_SRC_HI: rdata_o = src_hi_q;
      SEL_SRC_LO: rdata_o = src_lo_q;
      SEL_DST_HI: rdata_o = dst_hi_q;
      SEL_DST_LO: rdata_o = dst_lo_q;
      SEL_CTL:    rdata_o = ctl_q;
      default:    rdata_o = {DW{1'b1}};
    endcase
  end

  // R2
  reject_keeps_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && src_bad) |=> $stable(ctl_q));

  // R7
  blank_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && blank_q) |=> (ctl_q == DW'($past(ctl_q) - DW'(1))));
endmodule

// File: rtl/vram_blk_dma.sv
module vram_blk_dma
  import vram_blk_dma_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BLK_BYTES = 16,
  parameter int VRAM_BASE = 'h8000,
  parameter int VRAM_SIZE = 'h2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              hblank_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [2*DW-1:0]   mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              cpu_stall_o,
  output logic              busy_o
);
  localparam int AW    = 2 * DW;
  localparam int CNT_W = (DW - 1) + 1 + $clog2(BLK_BYTES);

  logic             load, go, active, done, blank;
  logic [AW-1:0]    src, dst, src_nxt, dst_nxt;
  logic [CNT_W-1:0] nbytes;

  vram_blk_dma_regs #(
    .AW(AW), .DW(DW), .BLK_BYTES(BLK_BYTES),
    .VRAM_BASE(VRAM_BASE), .VRAM_SIZE(VRAM_SIZE), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .hblank_i, .xfer_active_i(active), .done_i(done),
    .src_nxt_i(src_nxt), .dst_nxt_i(dst_nxt),
    .load_o(load), .src_o(src), .dst_o(dst),
    .go_o(go), .nbytes_o(nbytes), .blank_o(blank)
  );

  vram_blk_dma_xfer #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_xfer (
    .clk_i, .rst_ni,
    .load_i(load), .src_i(src), .dst_i(dst), .go_i(go), .nbytes_i(nbytes),
    .active_o(active), .done_o(done), .src_nxt_o(src_nxt), .dst_nxt_o(dst_nxt),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i
  );

  assign cpu_stall_o = active;
  assign busy_o      = active || blank;

  // R4
  stall_opens_with_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_stall_o) |-> (mem_req_o && !mem_we_o));
endmodule

// File: tb/tb_vram_blk_dma.sv
module tb_vram_blk_dma;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, hblank = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00, reg_rdata;
  logic        mem_req, mem_we, stall, busy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_req ? pat(mem_addr) : 8'h00;

  vram_blk_dma dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hblank_i(hblank),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .cpu_stall_o(stall), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_sel = sel; #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic pulse_hblank();
    @(negedge clk);
    hblank = 1'b1;
    @(posedge clk); #1;
    hblank = 1'b0;
  endtask

  task automatic idle_chk(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!mem_req && !stall, req, {mem_req, stall}, 0);
    end
  endtask

  task automatic xfer_chk(input logic [15:0] s, input logic [15:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] sa, da;
      sa = s + 16'(i);
      da = d + 16'(i);
      @(negedge clk);
      chk(mem_req && !mem_we && stall && mem_addr == sa, "R4 R5 read", mem_addr, sa);
      @(negedge clk);
      chk(mem_req && mem_we && stall && mem_addr == da, "R4 R5 write addr", mem_addr, da);
      chk(mem_wdata == pat(sa), "R4 write data", mem_wdata, pat(sa));
    end
  endtask

  localparam logic [39:0] VEC [5] = '{
    40'h12_34_00_00_00, 40'hC0_0F_9F_F0_01, 40'h01_FF_FF_FF_02,
    40'hA0_10_75_5A_03, 40'h7F_FF_80_00_00 };

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state, R12 read port
    @(negedge clk);
    chk(!busy && !stall && !mem_req, "R11 outputs", {busy, stall, mem_req}, 0);
    for (int s = 0; s < 5; s++) rd_chk(3'(s), 8'h00, "R11 regs");
    rd_chk(3'd5, 8'hFF, "R12 unused select");
    rd_chk(3'd7, 8'hFF, "R12 unused select");

    // R1 R3 R5 R6 general-mode vectors
    for (int k = 0; k < 5; k++) begin
      logic [39:0] v;
      logic [15:0] s, d, se, de;
      int n;
      v = VEC[k];
      s = {v[39:32], v[31:24]} & 16'hFFF0;
      d = ({v[23:16], v[15:8]} & 16'h1FF0) | 16'h8000;
      n = (int'(v[6:0]) + 1) * 16;
      se = s + 16'(n);
      de = d + 16'(n);
      wr(3'd0, v[39:32]); wr(3'd1, v[31:24]); wr(3'd2, v[23:16]); wr(3'd3, v[15:8]);
      wr(3'd4, v[7:0]);
      xfer_chk(s, d, n);
      @(negedge clk);
      chk(!busy && !stall, "R6 busy falls", {busy, stall}, 0);
      rd_chk(3'd0, se[15:8], "R6 src hi");
      rd_chk(3'd1, se[7:0], "R6 src lo");
      rd_chk(3'd2, de[15:8], "R6 dst hi");
      rd_chk(3'd3, de[7:0], "R6 dst lo");
      rd_chk(3'd4, v[7:0] | 8'h80, "R6 ctl bit7");
    end

    // R2 rejected sources at both window edges
    wr(3'd0, 8'h80); wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    chk(!busy, "R2 busy", busy, 0);
    idle_chk(4, "R2 no request");
    rd_chk(3'd4, 8'h80, "R2 ctl kept");
    wr(3'd0, 8'h9F); wr(3'd1, 8'hFF); wr(3'd4, 8'h81);
    idle_chk(2, "R2 no request");
    pulse_hblank();
    idle_chk(3, "R2 blank not armed");
    chk(!busy, "R2 busy", busy, 0);
    rd_chk(3'd4, 8'h80, "R2 ctl kept");

    // R7 R8 blanking mode, two blocks
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h81); wr(3'd3, 8'h00);
    wr(3'd4, 8'h81);
    @(negedge clk);
    chk(busy && !stall, "R8 busy while armed", {busy, stall}, 2'b10);
    idle_chk(4, "R7 waits for pulse");
    pulse_hblank();
    xfer_chk(16'h1230, 16'h8100, 16);
    @(negedge clk);
    chk(busy && !stall, "R8 busy between blocks", {busy, stall}, 2'b10);
    rd_chk(3'd4, 8'h80, "R7 ctl decrement");
    rd_chk(3'd1, 8'h40, "R7 src writeback");
    rd_chk(3'd3, 8'h10, "R7 dst writeback");
    pulse_hblank();
    xfer_chk(16'h1240, 16'h8110, 16);
    @(negedge clk);
    chk(!busy, "R8 disarmed", busy, 0);
    rd_chk(3'd4, 8'h7F, "R8 ctl final");
    pulse_hblank();
    idle_chk(4, "R8 pulse ignored");

    // R9 general write cancels armed blanking
    wr(3'd0, 8'h20); wr(3'd1, 8'h00);
    wr(3'd4, 8'h83);
    @(negedge clk);
    chk(busy, "R9 armed", busy, 1);
    wr(3'd4, 8'h02);
    @(negedge clk);
    chk(!busy, "R9 cancelled", busy, 0);
    idle_chk(3, "R9 no transfer");
    pulse_hblank();
    idle_chk(3, "R9 pulse ignored");

    // R10 control write during transfer ignored
    wr(3'd4, 8'h00);
    begin
      int nw;
      nw = 0;
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h85;
      @(posedge clk); #1;
      reg_we = 1'b0;
      for (int i = 0; i < 200 && busy; i++) begin
        @(negedge clk);
        if (mem_we) nw++;
      end
      chk(nw == 16, "R10 length unchanged", nw, 16);
      chk(!busy, "R10 ended", busy, 0);
      rd_chk(3'd4, 8'h80, "R10 ctl");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule